// File: doc/BRIEF.md
# Display Timing Register Bank Selector

This block is the timing register file of a display controller that drives a CRT and a flat panel. Software reaches every register through one index port and one data port. Writing the index port picks a register. Writing the data port then updates that register. A read of the data port returns the register the stored index points at. The registers fall into a standard timing set and an extended timing set. The extended set has one horizontal group and two vertical groups, one for 400-line modes and one for 350-line modes.

A control byte in the bank has three selection bits. One picks the source of the horizontal timing values. One picks the source of the vertical timing values. One write-protects the standard set. A separate miscellaneous register is written through its own port. Its top two bits choose which extended vertical group is used. An auxiliary register breaks the tie when that field leaves the choice open. The extended horizontal total is stored as the real total minus five, and the block adds the five back on its output. The outputs are the selected timing values, which feed the sync and pixel generators downstream.

Top module: `disp_timing_bank`

## Requirements
- R1: After reset, every register, the stored index and the miscellaneous register are 0. All timing outputs are 0, and a data-port read returns 0.
- R2: If the index and data ports are written in the same cycle, the data lands in the newly indexed register. The register stays readable on the data port while the index is unchanged. Index map: 0x00 std horizontal total, 0x01 std horizontal display end, 0x02 std vertical total, 0x03 std vertical display end, 0x10 control, 0x11 extended horizontal total, 0x12 extended horizontal display end, 0x13 auxiliary, 0x20/0x21 400-line vertical total/display end, 0x22/0x23 350-line vertical total/display end.
- R3: When control bit 0 is 1, the horizontal outputs come from the extended registers, and the horizontal total output equals the stored value plus 5 (9 bits wide, up to 260). When bit 0 is 0, the horizontal outputs come from the standard registers, unchanged.
- R4: When control bit 1 is 0, the vertical outputs come from the standard registers, whatever the miscellaneous register holds. Horizontal and vertical selection are independent of each other.
- R5: When control bit 1 is 1, miscellaneous bits 7:6 = 01 select the 400-line group and 10 select the 350-line group.
- R6: When control bit 1 is 1 and miscellaneous bits 7:6 = 11, auxiliary bit 0 decides the group: 1 selects the 350-line group and 0 selects the 400-line group.
- R7: When control bit 1 is 1 and miscellaneous bits 7:6 = 00, the vertical outputs fall back to the standard registers.
- R8: While control bit 2 is 1, data writes to the four standard registers are ignored, and reads still return their stored values. Writes to the extended, control and auxiliary registers still take effect.
- R9: Control bits 7:6 and auxiliary bits 7:1 are reserved: they read back as 0 whatever was written. The miscellaneous register reads back all 8 bits as written.
- R10: A data write to an unmapped index changes no register, and a read of an unmapped index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| idxWe | input | 1 | Index port write strobe |
| idxWrData | input | 8 | New index value |
| dataWe | input | 1 | Data port write strobe |
| dataWrData | input | 8 | Data written to the indexed register |
| dataRdData | output | 8 | Contents of the register the stored index points at |
| miscWe | input | 1 | Miscellaneous register write strobe |
| miscWrData | input | 8 | Miscellaneous register write data |
| miscRdData | output | 8 | Miscellaneous register contents |
| hTotal | output | 9 | Selected horizontal total |
| hDispEnd | output | 8 | Selected horizontal display end |
| vTotal | output | 8 | Selected vertical total |
| vDispEnd | output | 8 | Selected vertical display end |

## Verification
Each register group is loaded with its own distinct values, so every output value shows which source fed it. The bench then sweeps the four miscellaneous group codes against both auxiliary settings, with extended vertical timing both on and off. This tells the 400-line group, the 350-line group and the standard fallback apart, and shows that the horizontal choice does not move with them. The stored extended total is checked at a middle value and at 0xFF, where the added offset spills into the ninth output bit. Locked writes, reserved bits and unmapped indices are each checked by reading the register back through the data port and by watching the timing outputs.

// File: rtl/disp_timing_bank_pkg.sv
package disp_timing_bank_pkg;

  localparam int IDX_W     = 8;
  localparam int NUM_SLOTS = 12;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);

  typedef enum logic [SLOT_W-1:0] {
    SL_STD_HTOT  = 4'd0,
    SL_STD_HDE   = 4'd1,
    SL_STD_VTOT  = 4'd2,
    SL_STD_VDE   = 4'd3,
    SL_CTRL      = 4'd4,
    SL_EXT_HTOT  = 4'd5,
    SL_EXT_HDE   = 4'd6,
    SL_AUX       = 4'd7,
    SL_V400_TOT  = 4'd8,
    SL_V400_DE   = 4'd9,
    SL_V350_TOT  = 4'd10,
    SL_V350_DE   = 4'd11
  } slot_e;

  localparam logic [IDX_W-1:0] IDX_STD_HTOT = 8'h00;
  localparam logic [IDX_W-1:0] IDX_STD_HDE  = 8'h01;
  localparam logic [IDX_W-1:0] IDX_STD_VTOT = 8'h02;
  localparam logic [IDX_W-1:0] IDX_STD_VDE  = 8'h03;
  localparam logic [IDX_W-1:0] IDX_CTRL     = 8'h10;
  localparam logic [IDX_W-1:0] IDX_EXT_HTOT = 8'h11;
  localparam logic [IDX_W-1:0] IDX_EXT_HDE  = 8'h12;
  localparam logic [IDX_W-1:0] IDX_AUX      = 8'h13;
  localparam logic [IDX_W-1:0] IDX_V400_TOT = 8'h20;
  localparam logic [IDX_W-1:0] IDX_V400_DE  = 8'h21;
  localparam logic [IDX_W-1:0] IDX_V350_TOT = 8'h22;
  localparam logic [IDX_W-1:0] IDX_V350_DE  = 8'h23;

  // standard slots are the ones the lock protects
  localparam logic [NUM_SLOTS-1:0] STD_SLOT_MASK = 12'b0000_0000_1111;

  // control byte bit positions
  localparam int CTRL_HEXT_BIT = 0;
  localparam int CTRL_VEXT_BIT = 1;
  localparam int CTRL_LOCK_BIT = 2;
  localparam int AUX_PICK_BIT  = 0;

  typedef enum logic [1:0] {
    VS_STD  = 2'd0,
    VS_400  = 2'd1,
    VS_350  = 2'd2
  } vsrc_e;

  typedef struct packed {
    logic                 valid;
    slot_e                slot;
  } idx_hit_t;

  typedef struct packed {
    logic [NUM_SLOTS-1:0] wrStb;
    logic [NUM_SLOTS-1:0] rdSel;
    logic                 miscWr;
  } bank_stb_t;

  function automatic idx_hit_t decodeIdx(input logic [IDX_W-1:0] idx);
    idx_hit_t h;
    h.valid = 1'b1;
    h.slot  = SL_STD_HTOT;
    case (idx)
      IDX_STD_HTOT: h.slot = SL_STD_HTOT;
      IDX_STD_HDE:  h.slot = SL_STD_HDE;
      IDX_STD_VTOT: h.slot = SL_STD_VTOT;
      IDX_STD_VDE:  h.slot = SL_STD_VDE;
      IDX_CTRL:     h.slot = SL_CTRL;
      IDX_EXT_HTOT: h.slot = SL_EXT_HTOT;
      IDX_EXT_HDE:  h.slot = SL_EXT_HDE;
      IDX_AUX:      h.slot = SL_AUX;
      IDX_V400_TOT: h.slot = SL_V400_TOT;
      IDX_V400_DE:  h.slot = SL_V400_DE;
      IDX_V350_TOT: h.slot = SL_V350_TOT;
      IDX_V350_DE:  h.slot = SL_V350_DE;
      default:      h.valid = 1'b0;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/disp_timing_bank_ctl.sv
module disp_timing_bank_ctl
  import disp_timing_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             idxWe,
  input  logic [IDX_W-1:0] idxWrData,
  input  logic             dataWe,
  input  logic             miscWe,
  input  logic             lockOn,
  output bank_stb_t        stb
);

  logic [IDX_W-1:0] idxReg;
  logic [IDX_W-1:0] effIdx;
  idx_hit_t         wrHit;
  idx_hit_t         rdHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) idxReg <= '0;
    else if (idxWe) idxReg <= idxWrData;
  end

  // a same-cycle index write redirects the data write
  assign effIdx = idxWe ? idxWrData : idxReg;
  assign wrHit  = decodeIdx(effIdx);
  assign rdHit  = decodeIdx(idxReg);

  always_comb begin
    stb = '0;
    stb.miscWr = miscWe;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (wrHit.valid && dataWe && (wrHit.slot == slot_e'(i))) begin
        stb.wrStb[i] = !(STD_SLOT_MASK[i] && lockOn);
      end
      if (rdHit.valid && (rdHit.slot == slot_e'(i))) begin
        stb.rdSel[i] = 1'b1;
      end
    end
  end

  // R2
  wr_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.wrStb));

  // R10
  rd_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb.rdSel));

  // R8
  lock_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockOn |-> ((stb.wrStb & STD_SLOT_MASK) == '0));

endmodule

// File: rtl/disp_timing_bank_dp.sv
module disp_timing_bank_dp
  import disp_timing_bank_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HTOT_OFFSET = 5,
  localparam int TOT_W      = DATA_W + 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  bank_stb_t         stb,
  input  logic [DATA_W-1:0] dataWrData,
  input  logic [DATA_W-1:0] miscWrData,
  output logic [DATA_W-1:0] dataRdData,
  output logic [DATA_W-1:0] miscRdData,
  output logic              lockOn,
  output logic [TOT_W-1:0]  hTotal,
  output logic [DATA_W-1:0] hDispEnd,
  output logic [DATA_W-1:0] vTotal,
  output logic [DATA_W-1:0] vDispEnd
);

  localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'(8'h3F);
  localparam logic [DATA_W-1:0] AUX_MASK  = DATA_W'(1) << AUX_PICK_BIT;

  logic [DATA_W-1:0] regFile [NUM_SLOTS];
  logic [DATA_W-1:0] miscReg;
  vsrc_e             vSel;
  logic [1:0]        grpCode;

  function automatic logic [DATA_W-1:0] slotMask(input int s);
    if (s == int'(SL_CTRL)) return CTRL_MASK;
    if (s == int'(SL_AUX))  return AUX_MASK;
    return '1;
  endfunction

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) regFile[g] <= '0;
      else if (stb.wrStb[g]) regFile[g] <= dataWrData & slotMask(g);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) miscReg <= '0;
    else if (stb.miscWr) miscReg <= miscWrData;
  end

  always_comb begin
    dataRdData = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (stb.rdSel[i]) dataRdData = dataRdData | regFile[i];
    end
  end

  assign miscRdData = miscReg;
  assign lockOn     = regFile[SL_CTRL][CTRL_LOCK_BIT];
  assign grpCode    = miscReg[DATA_W-1 -: 2];

  always_comb begin
    vSel = VS_STD;
    if (regFile[SL_CTRL][CTRL_VEXT_BIT]) begin
      case (grpCode)
        2'b01:   vSel = VS_400;
        2'b10:   vSel = VS_350;
        2'b11:   vSel = regFile[SL_AUX][AUX_PICK_BIT] ? VS_350 : VS_400;
        default: vSel = VS_STD;
      endcase
    end
  end

  always_comb begin
    if (regFile[SL_CTRL][CTRL_HEXT_BIT]) begin
      hTotal   = TOT_W'(regFile[SL_EXT_HTOT]) + TOT_W'(HTOT_OFFSET);
      hDispEnd = regFile[SL_EXT_HDE];
    end else begin
      hTotal   = TOT_W'(regFile[SL_STD_HTOT]);
      hDispEnd = regFile[SL_STD_HDE];
    end
    case (vSel)
      VS_400: begin
        vTotal   = regFile[SL_V400_TOT];
        vDispEnd = regFile[SL_V400_DE];
      end
      VS_350: begin
        vTotal   = regFile[SL_V350_TOT];
        vDispEnd = regFile[SL_V350_DE];
      end
      default: begin
        vTotal   = regFile[SL_STD_VTOT];
        vDispEnd = regFile[SL_STD_VDE];
      end
    endcase
  end

  // R8
  std_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    lockOn |=> ($stable(regFile[SL_STD_HTOT]) && $stable(regFile[SL_STD_HDE])
                && $stable(regFile[SL_STD_VTOT]) && $stable(regFile[SL_STD_VDE])));

  // R9
  ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (!rstN)
    regFile[SL_CTRL][DATA_W-1:DATA_W-2] == 2'b00);

  // R3
  htot_floor_chk: assert property (@(posedge clk) disable iff (!rstN)
    regFile[SL_CTRL][CTRL_HEXT_BIT] |-> (hTotal >= TOT_W'(HTOT_OFFSET)));

  // R4
  vsel_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vSel != VS_STD) |-> regFile[SL_CTRL][CTRL_VEXT_BIT]);

  // R7
  grp_fallback_chk: assert property (@(posedge clk) disable iff (!rstN)
    (grpCode == 2'b00) |-> (vSel == VS_STD));

endmodule

// File: rtl/disp_timing_bank.sv
module disp_timing_bank
  import disp_timing_bank_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int HTOT_OFFSET = 5
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWe,
  input  logic [IDX_W-1:0]  idxWrData,
  input  logic              dataWe,
  input  logic [DATA_W-1:0] dataWrData,
  output logic [DATA_W-1:0] dataRdData,
  input  logic              miscWe,
  input  logic [DATA_W-1:0] miscWrData,
  output logic [DATA_W-1:0] miscRdData,
  output logic [DATA_W:0]   hTotal,
  output logic [DATA_W-1:0] hDispEnd,
  output logic [DATA_W-1:0] vTotal,
  output logic [DATA_W-1:0] vDispEnd
);

  bank_stb_t stb;
  logic      lockOn;

  disp_timing_bank_ctl uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .idxWe     (idxWe),
    .idxWrData (idxWrData),
    .dataWe    (dataWe),
    .miscWe    (miscWe),
    .lockOn    (lockOn),
    .stb       (stb)
  );

  disp_timing_bank_dp #(
    .DATA_W      (DATA_W),
    .HTOT_OFFSET (HTOT_OFFSET)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .dataWrData (dataWrData),
    .miscWrData (miscWrData),
    .dataRdData (dataRdData),
    .miscRdData (miscRdData),
    .lockOn     (lockOn),
    .hTotal     (hTotal),
    .hDispEnd   (hDispEnd),
    .vTotal     (vTotal),
    .vDispEnd   (vDispEnd)
  );

endmodule

// File: tb/sim_disp_timing_bank.sv
module sim_disp_timing_bank;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       idxWe = 1'b0;
  logic [7:0] idxWrData = '0;
  logic       dataWe = 1'b0;
  logic [7:0] dataWrData = '0;
  logic [7:0] dataRdData;
  logic       miscWe = 1'b0;
  logic [7:0] miscWrData = '0;
  logic [7:0] miscRdData;
  logic [8:0] hTotal;
  logic [7:0] hDispEnd;
  logic [7:0] vTotal;
  logic [7:0] vDispEnd;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  disp_timing_bank u0 (
    .clk(clk), .rstN(rstN), .idxWe(idxWe), .idxWrData(idxWrData),
    .dataWe(dataWe), .dataWrData(dataWrData), .dataRdData(dataRdData),
    .miscWe(miscWe), .miscWrData(miscWrData), .miscRdData(miscRdData),
    .hTotal(hTotal), .hDispEnd(hDispEnd), .vTotal(vTotal), .vDispEnd(vDispEnd)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    idxWe = 1'b1; idxWrData = idx; dataWe = 1'b1; dataWrData = d;
    @(negedge clk);
    idxWe = 1'b0; dataWe = 1'b0;
  endtask

  task automatic regRd(input logic [7:0] idx, output logic [7:0] v);
    @(negedge clk);
    idxWe = 1'b1; idxWrData = idx;
    @(negedge clk);
    idxWe = 1'b0;
    v = dataRdData;
  endtask

  task automatic miscWr(input logic [7:0] d);
    @(negedge clk);
    miscWe = 1'b1; miscWrData = d;
    @(negedge clk);
    miscWe = 1'b0;
  endtask

  task automatic loadAll();
    regWr(8'h10, 8'h00);
    regWr(8'h00, 8'h64); regWr(8'h01, 8'h50);
    regWr(8'h02, 8'hC0); regWr(8'h03, 8'hB0);
    regWr(8'h11, 8'h5B); regWr(8'h12, 8'h4F);
    regWr(8'h20, 8'hA1); regWr(8'h21, 8'h91);
    regWr(8'h22, 8'hA2); regWr(8'h23, 8'h92);
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 hTotal", hTotal, 0);
    check("R1 vTotal", vTotal, 0);
    check("R1 miscRd", miscRdData, 0);
    check("R1 dataRd idx0", dataRdData, 0);
    regRd(8'h22, v);
    check("R1 v350 total", v, 0);
  endtask

  task automatic testIndexData();
    logic [7:0] v;
    loadAll();
    check("R2 readback after same-cycle write", dataRdData, 8'h92);
    regRd(8'h00, v);
    check("R2 std htot read", v, 8'h64);
    regRd(8'h21, v);
    check("R2 v400 de read", v, 8'h91);
    check("R2 hTotal std", hTotal, 8'h64);
  endtask

  task automatic testHorizontal();
    regWr(8'h10, 8'h01);
    check("R3 ext hTotal offset", hTotal, 96);
    check("R3 ext hDispEnd", hDispEnd, 8'h4F);
    check("R4 vertical still std", vTotal, 8'hC0);
    regWr(8'h11, 8'hFF);
    check("R3 ext hTotal top", hTotal, 260);
    regWr(8'h11, 8'h5B);
    regWr(8'h10, 8'h00);
    check("R3 std hTotal", hTotal, 8'h64);
    check("R3 std hDispEnd", hDispEnd, 8'h50);
  endtask

  task automatic testVertical();
    miscWr(8'h40);
    check("R4 ext off ignores misc", vTotal, 8'hC0);
    regWr(8'h10, 8'h02);
    check("R5 code01 400 total", vTotal, 8'hA1);
    check("R5 code01 400 de", vDispEnd, 8'h91);
    check("R4 horizontal still std", hTotal, 8'h64);
    miscWr(8'h80);
    check("R5 code10 350 total", vTotal, 8'hA2);
    check("R5 code10 350 de", vDispEnd, 8'h92);
    miscWr(8'hC0);
    check("R6 code11 aux0 -> 400", vTotal, 8'hA1);
    regWr(8'h13, 8'h01);
    check("R6 code11 aux1 -> 350", vTotal, 8'hA2);
    check("R6 code11 aux1 de", vDispEnd, 8'h92);
    miscWr(8'h3F);
    check("R7 code00 fallback total", vTotal, 8'hC0);
    check("R7 code00 fallback de", vDispEnd, 8'hB0);
    check("R9 misc full readback", miscRdData, 8'h3F);
    regWr(8'h10, 8'h00);
    regWr(8'h13, 8'h00);
  endtask

  task automatic testLock();
    logic [7:0] v;
    regWr(8'h10, 8'h04);
    regWr(8'h00, 8'h77);
    check("R8 locked std write read", dataRdData, 8'h64);
    check("R8 locked hTotal", hTotal, 8'h64);
    regWr(8'h02, 8'h11);
    check("R8 locked vTotal", vTotal, 8'hC0);
    regWr(8'h11, 8'h10);
    check("R8 ext write while locked", dataRdData, 8'h10);
    regWr(8'h10, 8'h00);
    regRd(8'h10, v);
    check("R8 ctrl writable while locked", v, 0);
    regWr(8'h00, 8'h77);
    check("R8 unlocked std write", hTotal, 8'h77);
    regWr(8'h11, 8'h5B);
  endtask

  task automatic testReserved();
    logic [7:0] v;
    regWr(8'h10, 8'hFF);
    check("R9 ctrl reserved bits", dataRdData, 8'h3F);
    regWr(8'h10, 8'h00);
    regWr(8'h13, 8'hFE);
    check("R9 aux reserved bits", dataRdData, 8'h00);
    regWr(8'h13, 8'hFF);
    regRd(8'h13, v);
    check("R9 aux bit0 kept", v, 8'h01);
    regWr(8'h13, 8'h00);
  endtask

  task automatic testUnmapped();
    logic [7:0] v;
    regWr(8'h7F, 8'hAA);
    check("R10 unmapped read", dataRdData, 0);
    check("R10 hTotal untouched", hTotal, 8'h77);
    check("R10 vTotal untouched", vTotal, 8'hC0);
    regRd(8'h00, v);
    check("R10 std htot untouched", v, 8'h77);
    regRd(8'h10, v);
    check("R10 ctrl untouched", v, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIndexData();
    testHorizontal();
    testVertical();
    testLock();
    testReserved();
    testUnmapped();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule